// File: doc/BRIEF.md
# Host-Loaded Boot Window Controller

This block lets an external host place boot code into the chip's local data RAM and then hands that code to the on-chip processor. After reset it clears a semaphore word in the RAM. It then opens a 1 MiB host window and announces this through a range register that the host can poll. It waits until the host writes a fixed magic value into the semaphore word. When that value arrives, it asserts a remap output so the data RAM appears as instruction memory, and it issues a one-cycle start pulse carrying the first instruction address.

The host bus is a simple synchronous port: a request, a write enable, a register/memory select, a byte offset into the window, and write data. Read data returns one cycle after the request and holds until the next read. The two window registers can be read at any time, even while reset is held. Window offset N maps to internal address 0x0800_0000 + N. The data RAM sits at internal 0x0803_0000, which is host offset 0x3_0000. Only the data RAM can be reached through the window.

Top module: `hostboot_win`

## Requirements
- R1: With the register select high and offset bit 2 low, a read returns the range register. It reads 0x0000_0000 after reset and becomes 0x0010_0000 no more than 8 host reads after reset is released. Once it has changed, it stays at that value until the next reset.
- R2: A range register read made while rst_n is low returns 0x0000_0000.
- R3: With the register select high and offset bit 2 high, a read returns the offset register. It reads 0x0000_0000 before the window opens and 0x0800_0000 after. Memory-select offset N reaches internal address 0x0800_0000+N, so RAM word k is at host offset 0x3_0000+4k.
- R4: After every reset, and before the window opens, the block writes 0x0000_0000 into the semaphore word (host offset 0x3_0040). This clear has priority over host writes, so a host write of the magic value held across reset release has no effect.
- R5: A host write to the semaphore word with any value other than 0x6879_9786 leaves remap_o low. The magic value written to any other word also leaves remap_o low.
- R6: The clock edge that accepts a write of 0x6879_9786 to the semaphore word, while the block is waiting, also raises remap_o. One cycle later, start_o is high for exactly one cycle, with start_addr_o = 0x0000_0044. remap_o stays high until reset.
- R7: A memory access that does not land in the data RAM is discarded: reads return zero and writes change nothing. This covers offsets of 0x10_0000 and above, and offsets inside the window but outside 0x3_0000..0x3_03FF. Writes with the register select high also change nothing.
- R8: Before the window opens, including while reset is held, host memory writes are ignored and memory reads return zero.
- R9: A word written into the RAM through the window can be read back by the next request, including after remap.
- R10: While rst_n is low, remap_o and start_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hst_req | input | 1 | Host access request, one access per cycle |
| hst_we | input | 1 | 1 = write, 0 = read |
| hst_reg_sel | input | 1 | 1 = window registers, 0 = memory window |
| hst_addr | input | HADDR_W (21) | Byte offset into the window; bit 2 selects the register |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Read data, valid from the cycle after a read request |
| remap_o | output | 1 | Data RAM mapped as instruction memory |
| start_o | output | 1 | One-cycle processor start pulse |
| start_addr_o | output | 32 | First instruction address, valid with start_o |

## Verification
Two functions can fall in the same cycle: the block's own semaphore clear and a host write of the magic value to the semaphore word. The bench provokes this by holding a magic write to offset 0x3_0040 from inside reset until the window has opened. It then judges the outcome at the ports: the semaphore must read zero, and remap_o must stay low. The accepting write and the remap happen on the same edge. This is judged by sampling remap_o half a cycle after the accepting edge, and start_o on each of the next two half-cycles.

// File: rtl/hostboot_pkg.sv
// Package: shared state encoding and the handshake constant of the boot window.
// Assumes: used by every module of the host boot window block.
package hostboot_pkg;

    // Sequencer states, in the order the block walks through them.
    typedef enum logic [2:0] {
        ST_RESET_HOLD,
        ST_CLEAR_SEM,
        ST_PUBLISH_WINDOW,
        ST_WAIT_SEM,
        ST_REMAP,
        ST_RUN
    } boot_state_t;

    // Value that the host writes into the semaphore word to release the core.
    localparam logic [31:0] BOOT_MAGIC = 32'h6879_9786;

endpackage

// File: rtl/hostboot_seq.sv
// Module: hostboot_seq
// Walks the boot handshake: clear semaphore, open window, wait for magic,
// remap, start. Window enable, remap and start are registered outputs.
// Assumes: magic_seen is a single-cycle qualifier that is valid only in ST_WAIT_SEM.
module hostboot_seq
    import hostboot_pkg::*;
#(
    parameter logic [31:0] START_ADDR = 32'h0000_0044
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        magic_seen,
    output boot_state_t state_o,
    output logic        clr_req_o,
    output logic        win_en_o,
    output logic        remap_o,
    output logic        start_o,
    output logic [31:0] start_addr_o
);

    boot_state_t state_q;

    // State register, window enable, remap and start pulse generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_RESET_HOLD;
            win_en_o     <= 1'b0;
            remap_o      <= 1'b0;
            start_o      <= 1'b0;
            start_addr_o <= '0;
        end else begin
            start_o <= 1'b0;
            case (state_q)
                ST_RESET_HOLD:     state_q <= ST_CLEAR_SEM;
                ST_CLEAR_SEM:      state_q <= ST_PUBLISH_WINDOW;
                ST_PUBLISH_WINDOW: begin
                    state_q  <= ST_WAIT_SEM;
                    win_en_o <= 1'b1;
                end
                ST_WAIT_SEM: begin
                    if (magic_seen) begin
                        state_q <= ST_REMAP;
                        remap_o <= 1'b1;
                    end
                end
                ST_REMAP: begin
                    state_q      <= ST_RUN;
                    start_o      <= 1'b1;
                    start_addr_o <= START_ADDR;
                end
                ST_RUN:            state_q <= ST_RUN;
                default:           state_q <= ST_RESET_HOLD;
            endcase
        end
    end

    // Semaphore clear request, active for the single ST_CLEAR_SEM cycle.
    assign clr_req_o = (state_q == ST_CLEAR_SEM);
    assign state_o   = state_q;

endmodule

// File: rtl/hostboot_decode.sv
// Module: hostboot_decode
// Maps a host window offset to an internal address and decides whether it
// lands in the data RAM; gives the RAM word index.
// Assumes: RAM_BASE and RAM_BYTES are word aligned.
module hostboot_decode #(
    parameter int          HADDR_W   = 21,
    parameter int          IDX_W     = 8,
    parameter logic [31:0] WIN_BASE  = 32'h0800_0000,
    parameter logic [31:0] WIN_BYTES = 32'h0010_0000,
    parameter logic [31:0] RAM_BASE  = 32'h0803_0000,
    parameter logic [31:0] RAM_BYTES = 32'h0000_0400
) (
    input  logic [HADDR_W-1:0] host_addr,
    output logic               ram_hit,
    output logic [IDX_W-1:0]   ram_idx
);

    logic [31:0] off32;
    logic [31:0] internal;
    logic [31:0] diff;
    logic        in_win;

    // Window translation and data RAM range check.
    always_comb begin
        off32    = 32'(host_addr);
        in_win   = (off32 < WIN_BYTES);
        internal = WIN_BASE + off32;
        diff     = internal - RAM_BASE;
        ram_hit  = in_win && (internal >= RAM_BASE) && (diff < RAM_BYTES);
        ram_idx  = diff[IDX_W+1:2];
    end

endmodule

// File: rtl/hostboot_dram.sv
// Module: hostboot_dram
// Word-wide data RAM with one write port and one registered read port.
// Assumes: the caller has already arbitrated the write port; contents are not reset.
module hostboot_dram #(
    parameter int WORDS = 256,
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [31:0]      wr_data,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [31:0]      rd_data
);

    logic [31:0] mem [WORDS];

    // Storage write and registered read.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
        if (rd_en) begin
            rd_data <= mem[rd_idx];
        end
    end

endmodule

// File: rtl/hostboot_win.sv
// Module: hostboot_win (top)
// Host boot window controller. Joins the handshake sequencer, the window
// decoder and the data RAM. Provides the range and offset registers and
// arbitrates the RAM write port, with the semaphore clear ahead of the host.
// Assumes: one host access per cycle; read data is returned one cycle later
// and held until the next read. The read capture flops are data-only
// (not reset), so register reads also work while rst_n is low.
module hostboot_win
    import hostboot_pkg::*;
#(
    parameter int          HADDR_W    = 21,
    parameter int          RAM_WORDS  = 256,
    parameter logic [31:0] WIN_BASE   = 32'h0800_0000,
    parameter logic [31:0] WIN_BYTES  = 32'h0010_0000,
    parameter logic [31:0] RAM_BASE   = 32'h0803_0000,
    parameter logic [31:0] SEM_OFFSET = 32'h0000_0040,
    parameter logic [31:0] START_ADDR = 32'h0000_0044
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hst_req,
    input  logic               hst_we,
    input  logic               hst_reg_sel,
    input  logic [HADDR_W-1:0] hst_addr,
    input  logic [31:0]        hst_wdata,
    output logic [31:0]        hst_rdata,
    output logic               remap_o,
    output logic               start_o,
    output logic [31:0]        start_addr_o
);

    localparam int          IDX_W     = $clog2(RAM_WORDS);
    localparam logic [31:0] RAM_BYTES = 32'(RAM_WORDS * 4);
    localparam logic [IDX_W-1:0] SEM_IDX = IDX_W'(SEM_OFFSET >> 2);

    boot_state_t      state;
    logic             clr_req;
    logic             win_en;
    logic             magic_seen;
    logic             ram_hit;
    logic [IDX_W-1:0] ram_idx;
    logic             host_rd;
    logic             host_wr;
    logic             mem_wr_ok;
    logic             mem_rd_ok;
    logic             ram_we;
    logic [IDX_W-1:0] ram_widx;
    logic [31:0]      ram_wdata;
    logic [31:0]      ram_rdata;
    logic [31:0]      range_val;
    logic [31:0]      offset_val;
    logic             sel_reg_q;
    logic             ram_valid_q;
    logic [31:0]      reg_q;

    hostboot_seq #(
        .START_ADDR (START_ADDR)
    ) i_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .magic_seen   (magic_seen),
        .state_o      (state),
        .clr_req_o    (clr_req),
        .win_en_o     (win_en),
        .remap_o      (remap_o),
        .start_o      (start_o),
        .start_addr_o (start_addr_o)
    );

    hostboot_decode #(
        .HADDR_W   (HADDR_W),
        .IDX_W     (IDX_W),
        .WIN_BASE  (WIN_BASE),
        .WIN_BYTES (WIN_BYTES),
        .RAM_BASE  (RAM_BASE),
        .RAM_BYTES (RAM_BYTES)
    ) i_decode (
        .host_addr (hst_addr),
        .ram_hit   (ram_hit),
        .ram_idx   (ram_idx)
    );

    // Host access qualification: memory access only through an open window.
    always_comb begin
        host_rd    = hst_req && !hst_we;
        host_wr    = hst_req && hst_we;
        mem_wr_ok  = host_wr && !hst_reg_sel && ram_hit && win_en;
        mem_rd_ok  = host_rd && !hst_reg_sel && ram_hit && win_en;
        magic_seen = mem_wr_ok && (ram_idx == SEM_IDX) &&
                     (hst_wdata == BOOT_MAGIC) && (state == ST_WAIT_SEM);
    end

    // RAM write arbitration: the semaphore clear wins over any host write.
    always_comb begin
        if (clr_req) begin
            ram_we    = 1'b1;
            ram_widx  = SEM_IDX;
            ram_wdata = '0;
        end else begin
            ram_we    = mem_wr_ok;
            ram_widx  = ram_idx;
            ram_wdata = hst_wdata;
        end
    end

    hostboot_dram #(
        .WORDS (RAM_WORDS),
        .IDX_W (IDX_W)
    ) i_dram (
        .clk     (clk),
        .wr_en   (ram_we),
        .wr_idx  (ram_widx),
        .wr_data (ram_wdata),
        .rd_en   (mem_rd_ok),
        .rd_idx  (ram_idx),
        .rd_data (ram_rdata)
    );

    // Window register values, published together with the window enable.
    assign range_val  = win_en ? WIN_BYTES : 32'h0;
    assign offset_val = win_en ? WIN_BASE  : 32'h0;

    // Read capture: source select and register value at each read request.
    always_ff @(posedge clk) begin
        if (host_rd) begin
            sel_reg_q   <= hst_reg_sel;
            ram_valid_q <= mem_rd_ok;
            reg_q       <= hst_addr[2] ? offset_val : range_val;
        end
    end

    // Read data return: register, RAM word, or zero for a discarded access.
    assign hst_rdata = sel_reg_q   ? reg_q :
                       ram_valid_q ? ram_rdata : 32'h0;

endmodule

// File: rtl/hostboot_win_checker.sv
// Module: hostboot_win_checker
// Property checks on the host boot window, attached to hostboot_win by bind.
// Assumes: the signals seen through the bind are the top's internal nets.
module hostboot_win_checker #(
    parameter int          HADDR_W    = 21,
    parameter int          IDX_W      = 8,
    parameter logic [31:0] WIN_BYTES  = 32'h0010_0000,
    parameter logic [31:0] SEM_HOST   = 32'h0003_0040,
    parameter logic [31:0] START_ADDR = 32'h0000_0044,
    parameter logic [31:0] MAGIC      = 32'h6879_9786
) (
    input logic               clk,
    input logic               rst_n,
    input logic               hst_req,
    input logic               hst_we,
    input logic               hst_reg_sel,
    input logic [HADDR_W-1:0] hst_addr,
    input logic [31:0]        hst_wdata,
    input logic               win_en,
    input logic               clr_req,
    input logic               ram_we,
    input logic [IDX_W-1:0]   ram_widx,
    input logic [31:0]        ram_wdata,
    input logic               remap_o,
    input logic               start_o,
    input logic [31:0]        start_addr_o
);

    localparam logic [IDX_W-1:0] SEM_IDX = IDX_W'((SEM_HOST & 32'h3FF) >> 2);

    // R4: the clear writes zero into the semaphore word
    p_clear_sem_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req |-> (ram_we && ram_widx == SEM_IDX && ram_wdata == 32'h0));

    // R8: nothing but the clear reaches the RAM before the window opens
    p_closed_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!win_en && !clr_req) |-> !ram_we);

    // R7: register writes and offsets beyond the window never write the RAM
    p_outside_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hst_req && hst_we && !clr_req &&
         (hst_reg_sel || 32'(hst_addr) >= WIN_BYTES)) |-> !ram_we);

    // R5: a write without the magic value never raises remap
    p_non_magic_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (win_en && !remap_o && hst_req && hst_we && hst_wdata != MAGIC)
        |=> !remap_o);

    // R6: remap rises only after a magic write to the semaphore word
    p_remap_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(remap_o) |-> $past(hst_req && hst_we && !hst_reg_sel &&
                                 32'(hst_addr) == SEM_HOST && hst_wdata == MAGIC));

    // R6: remap holds until reset
    p_remap_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        remap_o |=> remap_o);

    // R6: start is a single-cycle pulse
    p_start_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o);

    // R6: start follows remap and carries the entry address
    p_start_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> (start_addr_o == START_ADDR && remap_o && $past(remap_o)));

    // R1: remap implies the window was published first
    p_remap_after_window_r1: assert property (@(posedge clk) disable iff (!rst_n)
        remap_o |-> win_en);

endmodule

bind hostboot_win hostboot_win_checker #(
    .HADDR_W    (HADDR_W),
    .IDX_W      (IDX_W),
    .WIN_BYTES  (WIN_BYTES),
    .SEM_HOST   (RAM_BASE + SEM_OFFSET - WIN_BASE),
    .START_ADDR (START_ADDR),
    .MAGIC      (hostboot_pkg::BOOT_MAGIC)
) i_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .hst_req      (hst_req),
    .hst_we       (hst_we),
    .hst_reg_sel  (hst_reg_sel),
    .hst_addr     (hst_addr),
    .hst_wdata    (hst_wdata),
    .win_en       (win_en),
    .clr_req      (clr_req),
    .ram_we       (ram_we),
    .ram_widx     (ram_widx),
    .ram_wdata    (ram_wdata),
    .remap_o      (remap_o),
    .start_o      (start_o),
    .start_addr_o (start_addr_o)
);

// File: tb/test_hostboot_win.sv
// Bench for hostboot_win: directed handshake corner cases plus seeded random
// RAM traffic, checked against a bench-side word model.
module test_hostboot_win;

    localparam int          AW        = 21;
    localparam logic [31:0] MAGIC     = 32'h6879_9786;
    localparam logic [AW-1:0] SEM_A   = 21'h03_0040;
    localparam logic [AW-1:0] TEST_A  = 21'h03_0044;
    localparam logic [31:0] RAM_HOST  = 32'h0003_0000;
    localparam int          WORDS     = 256;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hst_req = 1'b0;
    logic          hst_we = 1'b0;
    logic          hst_reg_sel = 1'b0;
    logic [AW-1:0] hst_addr = '0;
    logic [31:0]   hst_wdata = '0;
    logic [31:0]   hst_rdata;
    logic          remap_o;
    logic          start_o;
    logic [31:0]   start_addr_o;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    logic [31:0] model [WORDS];
    bit          known [WORDS];

    hostboot_win i_hostboot_win (
        .clk          (clk),
        .rst_n        (rst_n),
        .hst_req      (hst_req),
        .hst_we       (hst_we),
        .hst_reg_sel  (hst_reg_sel),
        .hst_addr     (hst_addr),
        .hst_wdata    (hst_wdata),
        .hst_rdata    (hst_rdata),
        .remap_o      (remap_o),
        .start_o      (start_o),
        .start_addr_o (start_addr_o)
    );

    always #4 clk = ~clk;

    // Expected data RAM hit for a host offset, from R3 and R7.
    function automatic bit exp_hit(input logic [AW-1:0] a);
        return (32'(a) >= RAM_HOST) && (32'(a) < RAM_HOST + 32'(WORDS * 4));
    endfunction

    function automatic int exp_idx(input logic [AW-1:0] a);
        return int'((32'(a) - RAM_HOST) >> 2);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic host_write(input bit rsel, input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        hst_req = 1'b1; hst_we = 1'b1; hst_reg_sel = rsel; hst_addr = a; hst_wdata = d;
        @(negedge clk);
        hst_req = 1'b0; hst_we = 1'b0;
    endtask

    task automatic host_read(input bit rsel, input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        hst_req = 1'b1; hst_we = 1'b0; hst_reg_sel = rsel; hst_addr = a;
        @(negedge clk);
        hst_req = 1'b0;
        d = hst_rdata;
    endtask

    task automatic wait_open(input string req);
        logic [31:0] v;
        int polls = 0;
        v = '0;
        while (v != 32'h0010_0000 && polls < 8) begin
            host_read(1'b1, 21'h0, v);
            polls++;
        end
        chk(req, v, 32'h0010_0000);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int unsigned seed;
        for (int i = 0; i < WORDS; i++) known[i] = 1'b0;
        seed = $urandom(32'h5EED_0042);

        // Reset phase: R2, R3, R10
        repeat (3) @(negedge clk);
        chk("R10 remap in reset", 32'(remap_o), 32'h0);
        chk("R10 start in reset", 32'(start_o), 32'h0);
        host_read(1'b1, 21'h0, v);
        chk("R2 range during reset", v, 32'h0);
        host_read(1'b1, 21'h4, v);
        chk("R3 offset before open", v, 32'h0);

        // Release and poll: R1
        @(negedge clk);
        rst_n = 1'b1;
        host_read(1'b1, 21'h0, v);
        chk("R1 range right after release", v, 32'h0);
        wait_open("R1 range published");
        host_read(1'b1, 21'h4, v);
        chk("R3 offset published", v, 32'h0800_0000);
        host_read(1'b0, SEM_A, v);
        chk("R4 semaphore cleared", v, 32'h0);
        model[16] = 32'h0; known[16] = 1'b1;

        // Test word read-after-write: R9
        host_write(1'b0, TEST_A, 32'hA5A5_5A5A);
        model[17] = 32'hA5A5_5A5A; known[17] = 1'b1;
        host_read(1'b0, TEST_A, v);
        chk("R9 test word readback", v, 32'hA5A5_5A5A);

        // Discarded accesses: R7
        host_write(1'b0, 21'h00_0000, 32'h1234_5678);
        host_read(1'b0, 21'h00_0000, v);
        chk("R7 in-window non-RAM read", v, 32'h0);
        host_write(1'b0, 21'h13_0044, 32'hBAD0_0001);
        host_write(1'b1, TEST_A, 32'hBAD0_0002);
        host_read(1'b0, TEST_A, v);
        chk("R7 out-of-window and register write ignored", v, 32'hA5A5_5A5A);
        host_read(1'b0, 21'h1F_FFFC, v);
        chk("R7 out-of-window read", v, 32'h0);
        host_read(1'b0, 21'h03_0400, v);
        chk("R7 just past RAM read", v, 32'h0);
        host_read(1'b1, 21'h0, v);
        chk("R1 range stays published", v, 32'h0010_0000);

        // Seeded random traffic: R5, R7, R9
        for (int n = 0; n < 400; n++) begin
            int op;
            int idx;
            logic [AW-1:0] a;
            logic [31:0] d;
            op  = int'($urandom_range(0, 5));
            idx = int'($urandom_range(18, WORDS - 1));
            d   = $urandom();
            if (d == MAGIC) d = ~d;
            case (op)
                0, 1: begin
                    a = AW'(RAM_HOST + 32'(idx * 4));
                    host_write(1'b0, a, d);
                    model[idx] = d; known[idx] = 1'b1;
                end
                2: begin
                    a = AW'(RAM_HOST + 32'(idx * 4));
                    host_read(1'b0, a, v);
                    if (known[idx]) chk("R9 random readback", v, model[idx]);
                end
                3: begin
                    host_write(1'b0, SEM_A, d);
                    model[16] = d;
                    chk("R5 non-magic semaphore write", 32'(remap_o), 32'h0);
                end
                4: begin
                    a = AW'($urandom());
                    if (exp_hit(a)) a = a ^ 21'h10_0000;
                    host_write(1'b0, a, d);
                    host_read(1'b0, a, v);
                    chk("R7 random discarded access", v, 32'h0);
                end
                default: begin
                    a = AW'(RAM_HOST + 32'(idx * 4));
                    host_write(1'b0, a, MAGIC);
                    model[idx] = MAGIC; known[idx] = 1'b1;
                    chk("R5 magic in other word", 32'(remap_o), 32'h0);
                end
            endcase
        end
        for (int i = 16; i < WORDS; i += 37) begin
            if (known[i]) begin
                host_read(1'b0, AW'(RAM_HOST + 32'(i * 4)), v);
                chk("R9 model sweep", v, model[i]);
            end
        end

        // Magic handshake: R6
        chk("R6 remap low before magic", 32'(remap_o), 32'h0);
        host_write(1'b0, SEM_A, MAGIC);
        model[16] = MAGIC;
        chk("R6 remap on accepting edge", 32'(remap_o), 32'h1);
        chk("R6 no start yet", 32'(start_o), 32'h0);
        @(negedge clk);
        chk("R6 start pulse", 32'(start_o), 32'h1);
        chk("R6 start address", start_addr_o, 32'h0000_0044);
        @(negedge clk);
        chk("R6 start one cycle", 32'(start_o), 32'h0);
        chk("R6 remap held", 32'(remap_o), 32'h1);
        host_read(1'b0, SEM_A, v);
        chk("R9 semaphore readback after remap", v, MAGIC);

        // Second reset with clear versus held magic write: R4, R8, R10
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R10 remap cleared by reset", 32'(remap_o), 32'h0);
        host_write(1'b0, TEST_A, 32'hDEAD_0001);
        host_read(1'b0, TEST_A, v);
        chk("R8 read before open", v, 32'h0);
        @(negedge clk);
        hst_req = 1'b1; hst_we = 1'b1; hst_reg_sel = 1'b0;
        hst_addr = SEM_A; hst_wdata = MAGIC;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        hst_req = 1'b0; hst_we = 1'b0;
        wait_open("R1 republished");
        host_read(1'b0, SEM_A, v);
        chk("R4 clear beats held magic write", v, 32'h0);
        chk("R4 no remap from held write", 32'(remap_o), 32'h0);
        host_read(1'b0, TEST_A, v);
        chk("R8 write in reset ignored", v, 32'hA5A5_5A5A);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule